// File: doc/BRIEF.md
# Multi-Clock Mailbox Interrupt Controller

This block produces the mailbox interrupts for a shared memory with four ports, where each port runs on its own clock. Every port owns one mailbox word near the top of the address space. A write to that word by any port raises the owner's interrupt. A read of the word by the owner drops it. The block sees each port's address and its read and write strobes. It drives one active-low interrupt line per port. It holds no data and no memory array.

Each interrupt flag is a register in its owner's clock domain. A write from another port is a set event in a foreign domain. That event crosses into the owner's domain over a request/acknowledge toggle handshake. While a crossing is in flight, further writes from the same port to the same mailbox merge into one pending set, so no set event is dropped. The owner's read is a clear event. It already lives in the owner's domain and needs no crossing. The reset input is asynchronous and active low. Each clock domain releases it through its own synchronizer.

Top module: `mbx_irq_ctrl`

## Requirements
- R1: After reset, every interrupt output is high (inactive), and it stays high until a mailbox write occurs.
- R2: The mailbox of port k (index 0 to 3) is at address 2^AW-1-k, which is FFFFh, FFFEh, FFFDh and FFFCh for a 16-bit address. Bit k of every per-port bus belongs to port k.
- R3: A write strobe by any port k, sampled on a rising edge of clock k with the address equal to port j's mailbox, drives interrupt j low. If k equals j, the output goes low right after that edge. Otherwise it goes low within three rising edges of clock j, counted after the write edge.
- R4: A read strobe by port j at its own mailbox address, sampled on a rising edge of clock j with no set arriving in the same cycle, drives interrupt j high after that edge.
- R5: A read of port j's mailbox by any other port leaves interrupt j unchanged.
- R6: A write to a mailbox changes no other port's interrupt. Reads and writes at addresses that are not mailboxes change no interrupt.
- R7: When a set and a clear reach a flag in the same owner cycle, the set wins and the interrupt stays or becomes low.
- R8: Several writes from one port to one mailbox, issued before the earlier ones are delivered, each produce at most one further set. The last of them is never lost. After all of them have settled, a single owner read leaves the interrupt high for good.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| rst_n | input | 1 | Asynchronous active-low reset, released per domain |
| port_clk | input | NP | One clock per port, bit k is port k's clock |
| port_addr | input | NP x AW | Address of each port, sampled on that port's clock |
| port_wr | input | NP | Write strobe of each port |
| port_rd | input | NP | Read strobe of each port |
| port_irq_n | output | NP | Active-low mailbox interrupt of each port |

## Verification
The bench uses the default build: four ports, a 16-bit address and two-stage synchronizers. It runs the four port clocks at four unrelated periods, so every crossing goes between domains that drift against each other. This small build lets the bench sweep all sixteen writer/owner pairs, every non-owner read, and addresses just outside the mailbox range. It also reaches the same-cycle set/clear case through a port that reads and writes its own mailbox at once, and it sends back-to-back write bursts through a crossing that is still busy.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

  localparam int unsigned SYNC_STAGES_DEF = 2;

  // source-side state of one set-event crossing
  typedef struct packed {
    logic pend;
    logic req;
  } mbx_tx_t;

endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign srst_n = sh_q[STAGES-1];

endmodule

// File: rtl/mbx_bit_sync.sv
module mbx_bit_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign q = sh_q[STAGES-1];

endmodule

// File: rtl/mbx_evt_tx.sv
module mbx_evt_tx
  import mbx_irq_pkg::*;
#(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic ack_async,
  output logic req
);

  mbx_tx_t st_q;
  mbx_tx_t st_d;
  logic    ack_s;
  logic    idle;
  logic    launch;

  mbx_bit_sync #(.STAGES(STAGES)) u_ack_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (ack_async),
    .q     (ack_s)
  );

  always_comb begin
    idle     = (st_q.req == ack_s);
    launch   = (evt | st_q.pend) & idle;
    st_d.req = st_q.req ^ launch;
    st_d.pend = (evt | st_q.pend) & ~idle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= '0;
    end else begin
      st_q <= st_d;
    end
  end

  assign req = st_q.req;

  // R8: no new request while the previous one is unacknowledged
  p_busy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q.req != ack_s) |=> $stable(st_q.req));

  // R8: an event is either launched or kept pending, never dropped
  p_evt_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    evt |=> (st_q.pend || (st_q.req != $past(st_q.req))));

endmodule

// File: rtl/mbx_evt_rx.sv
module mbx_evt_rx #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic ack,
  output logic pulse
);

  logic req_s;
  logic seen_q;
  logic seen_d;

  mbx_bit_sync #(.STAGES(STAGES)) u_req_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (req_async),
    .q     (req_s)
  );

  always_comb begin
    seen_d = req_s;
    pulse  = req_s ^ seen_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
    end else begin
      seen_q <= seen_d;
    end
  end

  assign ack = seen_q;

  // R8: one request toggle yields exactly one single-cycle set pulse
  p_single_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);

endmodule

// File: rtl/mbx_flag.sv
module mbx_flag #(
  parameter int unsigned NSET = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSET-1:0] set_vec,
  input  logic            clr,
  output logic            flag
);

  logic set_any;
  logic flag_q;
  logic flag_d;

  always_comb begin
    set_any = |set_vec;
    flag_d  = set_any | (flag_q & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
    end
  end

  assign flag = flag_q;

  p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    set_any |=> flag_q);

  p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set_any) |=> !flag_q);

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && set_any) |=> flag_q);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !set_any) |=> $stable(flag_q));

endmodule

// File: rtl/mbx_irq_ctrl.sv
module mbx_irq_ctrl
  import mbx_irq_pkg::*;
#(
  parameter int unsigned NP          = 4,
  parameter int unsigned AW          = 16,
  parameter int unsigned SYNC_STAGES = SYNC_STAGES_DEF
) (
  input  logic                   rst_n,
  input  logic [NP-1:0]          port_clk,
  input  logic [NP-1:0][AW-1:0]  port_addr,
  input  logic [NP-1:0]          port_wr,
  input  logic [NP-1:0]          port_rd,
  output logic [NP-1:0]          port_irq_n
);

  logic [NP-1:0]         dom_rst_n;
  // [writer][owner]
  logic [NP-1:0][NP-1:0] wr_hit;
  logic [NP-1:0][NP-1:0] xreq;
  logic [NP-1:0][NP-1:0] xack;
  // [owner][writer]
  logic [NP-1:0][NP-1:0] set_mx;
  logic [NP-1:0]         clr_own;
  logic [NP-1:0]         flag;

  for (genvar d = 0; d < NP; d++) begin : g_dom
    mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
      .clk    (port_clk[d]),
      .arst_n (rst_n),
      .srst_n (dom_rst_n[d])
    );
  end

  for (genvar j = 0; j < NP; j++) begin : g_own
    localparam logic [AW-1:0] MBX = ~AW'(j);

    assign clr_own[j] = port_rd[j] & (port_addr[j] == MBX);

    for (genvar i = 0; i < NP; i++) begin : g_wr
      assign wr_hit[i][j] = port_wr[i] & (port_addr[i] == MBX);

      if (i == j) begin : g_local
        assign set_mx[j][i] = wr_hit[i][j];
        assign xreq[i][j]   = 1'b0;
        assign xack[i][j]   = 1'b0;
      end else begin : g_cross
        mbx_evt_tx #(.STAGES(SYNC_STAGES)) u_tx (
          .clk       (port_clk[i]),
          .rst_n     (dom_rst_n[i]),
          .evt       (wr_hit[i][j]),
          .ack_async (xack[i][j]),
          .req       (xreq[i][j])
        );
        mbx_evt_rx #(.STAGES(SYNC_STAGES)) u_rx (
          .clk       (port_clk[j]),
          .rst_n     (dom_rst_n[j]),
          .req_async (xreq[i][j]),
          .ack       (xack[i][j]),
          .pulse     (set_mx[j][i])
        );
      end
    end

    mbx_flag #(.NSET(NP)) u_flag (
      .clk     (port_clk[j]),
      .rst_n   (dom_rst_n[j]),
      .set_vec (set_mx[j]),
      .clr     (clr_own[j]),
      .flag    (flag[j])
    );

    assign port_irq_n[j] = ~flag[j];

    // R5: a read of this mailbox by another port never lowers the flag
    p_nonowner_read_r5: assert property (@(posedge port_clk[j]) disable iff (!dom_rst_n[j])
      (!port_rd[j] && flag[j]) |=> flag[j]);
  end

endmodule

// File: tb/mbx_irq_ctrl_test.sv
module mbx_irq_ctrl_test;

  localparam int NP = 4;
  localparam int AW = 16;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 30 * (CLK_PERIOD + 2 * 2 * (NP - 1));

  logic                  rst_n = 1'b0;
  logic [NP-1:0]         clk   = '0;
  logic [NP-1:0][AW-1:0] addr  = '0;
  logic [NP-1:0]         wr    = '0;
  logic [NP-1:0]         rd    = '0;
  logic [NP-1:0]         irq_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  mbx_irq_ctrl #(.NP(NP), .AW(AW), .SYNC_STAGES(2)) uut (
    .rst_n      (rst_n),
    .port_clk   (clk),
    .port_addr  (addr),
    .port_wr    (wr),
    .port_rd    (rd),
    .port_irq_n (irq_n)
  );

  for (genvar p = 0; p < NP; p++) begin : g_clk
    initial begin
      forever #(CLK_PERIOD / 2 + 2 * p) clk[p] = ~clk[p];
    end
  end

  function automatic logic [AW-1:0] mbx(input int k);
    return AW'((1 << AW) - 1 - k);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_irq(input int k, input logic exp, input string tag);
    @(negedge clk[k]);
    chk(irq_n[k] === exp, tag, int'(irq_n[k]), int'(exp));
  endtask

  task automatic op(input int p, input logic [AW-1:0] a, input logic w, input logic r);
    @(negedge clk[p]);
    addr[p] = a;
    wr[p]   = w;
    rd[p]   = r;
    @(negedge clk[p]);
    wr[p]   = 1'b0;
    rd[p]   = 1'b0;
    addr[p] = '0;
  endtask

  initial begin
    #(200 * SETTLE);
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    fails++;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(5 * CLK_PERIOD);
    rst_n = 1'b1;
    #(SETTLE);

    // R1: reset state
    for (int k = 0; k < NP; k++) expect_irq(k, 1'b1, "R1 reset irq high");

    // R2 R3 R6 R4: every writer/owner pair
    for (int i = 0; i < NP; i++) begin
      for (int j = 0; j < NP; j++) begin
        op(i, mbx(j), 1'b1, 1'b0);
        if (i == j) chk(irq_n[j] === 1'b0, "R3 self write next edge", int'(irq_n[j]), 0);
        #(SETTLE);
        for (int k = 0; k < NP; k++) begin
          if (k == j) expect_irq(k, 1'b0, "R2 R3 write sets owner irq");
          else        expect_irq(k, 1'b1, "R6 other irq untouched");
        end
        op(j, mbx(j), 1'b0, 1'b1);
        expect_irq(j, 1'b1, "R4 owner read clears");
        #(SETTLE);
      end
    end

    // R5: non-owner reads leave the flag set
    for (int j = 0; j < NP; j++) begin
      op(j, mbx(j), 1'b1, 1'b0);
      for (int r = 0; r < NP; r++) begin
        if (r != j) op(r, mbx(j), 1'b0, 1'b1);
      end
      #(SETTLE);
      expect_irq(j, 1'b0, "R5 non-owner read ignored");
      op(j, mbx(j), 1'b0, 1'b1);
      expect_irq(j, 1'b1, "R4 owner read clears");
    end

    // R6: non-mailbox addresses and idle strobes
    for (int p = 0; p < NP; p++) begin
      op(p, mbx(NP), 1'b1, 1'b0);
      op(p, 16'h0000, 1'b1, 1'b1);
      op(p, 16'h7FFF, 1'b1, 1'b0);
      op(p, mbx(p), 1'b0, 1'b0);
    end
    #(SETTLE);
    for (int k = 0; k < NP; k++) expect_irq(k, 1'b1, "R6 non-mailbox access ignored");

    // R7: set and clear in the same owner cycle
    for (int j = 0; j < NP; j++) begin
      op(j, mbx(j), 1'b1, 1'b1);
      chk(irq_n[j] === 1'b0, "R7 set wins from clear state", int'(irq_n[j]), 0);
      op(j, mbx(j), 1'b1, 1'b1);
      chk(irq_n[j] === 1'b0, "R7 set wins from set state", int'(irq_n[j]), 0);
      op(j, mbx(j), 1'b0, 1'b1);
      expect_irq(j, 1'b1, "R4 owner read clears");
    end

    // R8: bursts through a busy crossing
    for (int i = 0; i < NP; i++) begin
      int j = (i + 1) % NP;
      @(negedge clk[i]);
      addr[i] = mbx(j);
      wr[i]   = 1'b1;
      repeat (3) @(negedge clk[i]);
      wr[i]   = 1'b0;
      addr[i] = '0;
      #(SETTLE);
      expect_irq(j, 1'b0, "R8 burst delivered");
      op(j, mbx(j), 1'b0, 1'b1);
      #(SETTLE);
      expect_irq(j, 1'b1, "R8 no stale set after clear");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule